// File: doc/BRIEF.md
# Flash Command Snoop and Bit Striper

This block sits between a transmit byte queue and one or two parallel serial flash data buses. It watches the traffic of each chip-select frame. The first byte of a frame is treated as a flash command. Read and program commands start a countdown that covers their address bytes and dummy bytes. When the countdown finishes, the block enters a striping mode for the rest of the frame. In striping mode, two queued bytes are spread bit by bit across the two buses, and the bytes returned by the buses are put back into their original order.

Outside striping mode, and whenever only one bus is in effect, one queued byte is copied onto every bus. Only the byte returned on bus 0 is passed on to the receive queue. The serial engine is outside this block. It receives a launch strobe with the per-bus bytes, and later presents the returned bytes together with a valid pulse. Two configuration inputs choose the bus count. The block does nothing to a queue except report how many bytes to pop or push, and it flags underflow and overflow.

Top module: `flash_snoop_striper`

## Requirements
- R1: After reset, and after any cycle in which `cs_active` is low, the next launched byte is decoded as a command: it pops exactly one byte and is copied to both buses.
- R2: Commands 0x03, 0x02, 0xA2 and 0x32 are followed by 3 unstriped bytes. Commands 0x0B, 0x3B, 0x6B and 0xBB are followed by 4. Command 0xEB is followed by 6. Every later launch in the same frame is striped.
- R3: Any other command leaves the rest of the frame unstriped, however many bytes follow.
- R4: An unstriped launch pops one byte (`tx_pop_cnt`=1) and drives `tx_head[7:0]` onto both halves of `bus_tx`. Its return pushes one byte (`rx_push_cnt`=1), which is `bus_rx[7:0]`, placed in `rx_push_data[7:0]`.
- R5: A striped launch with two buses pops two bytes. Here `tx_head[7:0]` is input byte 0 and `tx_head[15:8]` is input byte 1. Bus i (`bus_tx[8i+7:8i]`), bit b, carries input byte (k mod 2), bit (k div 2), where k = 8i+b.
- R6: The return of a striped launch applies the inverse mapping to `bus_rx` and pushes two bytes, with byte 0 in `rx_push_data[7:0]`.
- R7: When `rx_valid` arrives while `rx_full` is high, `overflow_evt` pulses and nothing is pushed.
- R8: When a request finds fewer bytes in `tx_level` than the launch needs (2 when striping on two buses, 1 otherwise), `underflow_evt` pulses. Nothing is launched or popped, and the snoop state is left unchanged.
- R9: Two buses are in effect only when both `cfg_two_mem` and `cfg_sep_bus` are high. Otherwise striping is the identity: one byte is popped and copied to both buses, and one byte is pushed.
- R10: A request made while `cs_active` is low launches nothing and raises no underflow.
- R11: Once a frame is striping, it keeps striping until `cs_active` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_two_mem | input | 1 | Two memories fitted |
| cfg_sep_bus | input | 1 | Memories on separate data buses |
| cs_active | input | 1 | Some chip select is asserted |
| xfer_req | input | 1 | Request one transfer this cycle |
| tx_head | input | 16 | Two oldest transmit queue bytes, oldest in [7:0] |
| tx_level | input | LVL_W | Bytes held in the transmit queue |
| bus_launch | output | 1 | Transfer launched this cycle |
| bus_tx | output | 16 | Byte for bus i in [8i+7:8i] |
| tx_pop_cnt | output | 2 | Bytes to pop from the transmit queue |
| underflow_evt | output | 1 | Transmit queue had too few bytes |
| rx_valid | input | 1 | Returned bus bytes are valid |
| bus_rx | input | 16 | Byte returned on bus i in [8i+7:8i] |
| rx_full | input | 1 | Receive queue is full |
| rx_push_cnt | output | 2 | Bytes to push into the receive queue |
| rx_push_data | output | 16 | Bytes to push, first in [7:0] |
| overflow_evt | output | 1 | Returned data dropped because the queue was full |

## Verification
Several rules are checked by the assertions on every cycle:
- a command byte is always an unstriped single pop;
- a striping frame stays striped;
- unstriped launches send identical bytes on both buses;
- underflow and overflow cycles neither pop nor push;
- an inactive chip select launches nothing.

Other behaviour can only be shown by the bench's scenarios:
- the exact bit mapping in both directions;
- the countdown length for each command class;
- that an unknown command never stripes;
- that a single-bus configuration stays unstriped.

// File: rtl/flash_snoop_striper.sv
module flash_snoop_striper #(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_two_mem,
  input  logic             cfg_sep_bus,
  input  logic             cs_active,
  input  logic             xfer_req,
  input  logic [15:0]      tx_head,
  input  logic [LVL_W-1:0] tx_level,
  output logic             bus_launch,
  output logic [15:0]      bus_tx,
  output logic [1:0]       tx_pop_cnt,
  output logic             underflow_evt,
  input  logic             rx_valid,
  input  logic [15:0]      bus_rx,
  input  logic             rx_full,
  output logic [1:0]       rx_push_cnt,
  output logic [15:0]      rx_push_data,
  output logic             overflow_evt
);
  localparam int NB = 2;
  localparam int BW = 8;
  localparam int DW = NB * BW;
  localparam logic [7:0] ST_CHECK  = 8'hFF;
  localparam logic [7:0] ST_NONE   = 8'hFE;
  localparam logic [7:0] ST_STRIPE = 8'h00;

  function automatic logic [DW-1:0] spread(input logic [DW-1:0] x);
    logic [DW-1:0] o;
    for (int k = 0; k < DW; k++) o[k] = x[BW*(k % NB) + k / NB];
    return o;
  endfunction

  function automatic logic [DW-1:0] gather(input logic [DW-1:0] r);
    logic [DW-1:0] d;
    for (int k = 0; k < DW; k++) d[BW*(k % NB) + k / NB] = r[k];
    return d;
  endfunction

  function automatic logic [7:0] decode(input logic [7:0] op);
    case (op)
      8'h03, 8'h02, 8'hA2, 8'h32: return 8'd3;
      8'h0B, 8'h3B, 8'h6B, 8'hBB: return 8'd4;
      8'hEB:                      return 8'd6;
      default:                    return ST_NONE;
    endcase
  endfunction

  logic [7:0] snoop_q, snoop_d;
  logic       striped_q;
  logic       two_bus, wide, fire;
  logic [1:0] need;

  assign two_bus = cfg_two_mem & cfg_sep_bus;
  assign wide    = two_bus && (snoop_q == ST_STRIPE);
  assign need    = wide ? 2'd2 : 2'd1;
  assign fire    = xfer_req & cs_active;

  assign bus_launch    = fire && (tx_level >= LVL_W'(need));
  assign underflow_evt = fire && (tx_level <  LVL_W'(need));
  assign tx_pop_cnt    = bus_launch ? need : 2'd0;
  assign bus_tx        = wide ? spread(tx_head) : {tx_head[7:0], tx_head[7:0]};

  assign overflow_evt  = rx_valid & rx_full;
  assign rx_push_cnt   = (rx_valid & ~rx_full) ? (striped_q ? 2'd2 : 2'd1) : 2'd0;
  assign rx_push_data  = striped_q ? gather(bus_rx) : {8'h00, bus_rx[7:0]};

  always_comb begin
    snoop_d = snoop_q;
    if (!cs_active) snoop_d = ST_CHECK;
    else if (bus_launch) begin
      case (snoop_q)
        ST_CHECK:           snoop_d = decode(tx_head[7:0]);
        ST_NONE, ST_STRIPE: snoop_d = snoop_q;
        default:            snoop_d = snoop_q - 8'd1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snoop_q   <= ST_CHECK;
      striped_q <= 1'b0;
    end else begin
      snoop_q <= snoop_d;
      if (bus_launch) striped_q <= wide;
    end
  end
endmodule

// File: rtl/flash_snoop_striper_chk.sv
module flash_snoop_striper_chk #(
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_two_mem,
  input logic             cfg_sep_bus,
  input logic             cs_active,
  input logic             xfer_req,
  input logic [15:0]      tx_head,
  input logic [LVL_W-1:0] tx_level,
  input logic             bus_launch,
  input logic [15:0]      bus_tx,
  input logic [1:0]       tx_pop_cnt,
  input logic             underflow_evt,
  input logic             rx_valid,
  input logic [15:0]      bus_rx,
  input logic             rx_full,
  input logic [1:0]       rx_push_cnt,
  input logic [15:0]      rx_push_data,
  input logic             overflow_evt
);
  logic stripe_seen;
  always_ff @(posedge clk) begin
    if (!rst_n || !cs_active) stripe_seen <= 1'b0;
    else if (bus_launch && tx_pop_cnt == 2'd2) stripe_seen <= 1'b1;
  end

  a_r1_command_first: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_launch && $past(!cs_active)) |-> tx_pop_cnt == 2'd1);
  a_r4_copy_both: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_launch && tx_pop_cnt == 2'd1) |-> bus_tx[15:8] == bus_tx[7:0]);
  a_r7_no_push_on_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_evt |-> rx_push_cnt == 2'd0);
  a_r8_no_pop_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_evt |-> (tx_pop_cnt == 2'd0 && !bus_launch));
  a_r9_single_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_two_mem && cfg_sep_bus) |-> tx_pop_cnt != 2'd2);
  a_r10_idle_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |-> (!bus_launch && !underflow_evt));
  a_r11_stripe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_launch && stripe_seen && cs_active && cfg_two_mem && cfg_sep_bus) |-> tx_pop_cnt == 2'd2);
endmodule

bind flash_snoop_striper flash_snoop_striper_chk #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/flash_snoop_striper_tb.sv
module flash_snoop_striper_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W = 6;

  // {opcode, unstriped bytes after it; 8'hFF = never stripes}
  localparam logic [15:0] OPS [11] = '{
    16'h03_03, 16'h02_03, 16'hA2_03, 16'h32_03,
    16'h0B_04, 16'h3B_04, 16'h6B_04, 16'hBB_04,
    16'hEB_06, 16'h9F_FF, 16'h05_FF};
  // {in1, in0, bus1, bus0}
  localparam logic [31:0] SV [5] = '{
    32'h3C_A5_4E_B1, 32'h00_FF_55_55, 32'hFF_00_AA_AA,
    32'hF0_0F_AA_55, 32'h80_01_80_01};

  logic clk = 0, rst_n = 0;
  logic cfg_two_mem = 1, cfg_sep_bus = 1, cs_active = 0, xfer_req = 0;
  logic [15:0] tx_head = 0;
  logic [LVL_W-1:0] tx_level = 0;
  logic rx_valid = 0, rx_full = 0;
  logic [15:0] bus_rx = 0;
  logic bus_launch, underflow_evt, overflow_evt;
  logic [15:0] bus_tx, rx_push_data;
  logic [1:0] tx_pop_cnt, rx_push_cnt;

  int checks = 0, failures = 0;
  bit done = 0;

  flash_snoop_striper #(.LVL_W(LVL_W)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic o_launch, o_under;
  logic [1:0] o_pop;
  logic [15:0] o_bus;

  task automatic send(input logic [7:0] b0, input logic [7:0] b1, input int lvl);
    @(negedge clk);
    cs_active = 1; tx_head = {b1, b0}; tx_level = LVL_W'(lvl); xfer_req = 1;
    #1;
    o_launch = bus_launch; o_under = underflow_evt; o_pop = tx_pop_cnt; o_bus = bus_tx;
    @(posedge clk); #1 xfer_req = 0;
  endtask

  logic o_over;
  logic [1:0] o_push;
  logic [15:0] o_data;

  task automatic ret(input logic [15:0] r, input bit full);
    @(negedge clk);
    bus_rx = r; rx_full = full; rx_valid = 1;
    #1;
    o_over = overflow_evt; o_push = rx_push_cnt; o_data = rx_push_data;
    @(posedge clk); #1 rx_valid = 0; rx_full = 0;
  endtask

  task automatic end_frame();
    @(negedge clk); cs_active = 0;
    @(posedge clk);
  endtask

  task automatic enter_stripe();
    send(8'h03, 8'h00, 4);
    for (int j = 0; j < 3; j++) send(8'h40 + 8'(j), 8'h00, 4);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check(bus_launch == 0 && tx_pop_cnt == 0 && rx_push_cnt == 0, "R1 reset idle",
          {bus_launch, tx_pop_cnt, rx_push_cnt}, 0);

    // R2 R3 R5: command table
    for (int t = 0; t < 11; t++) begin
      logic [7:0] op, cnt;
      op = OPS[t][15:8]; cnt = OPS[t][7:0];
      send(op, 8'h77, 8);
      check(o_launch && o_pop == 1 && o_bus == {op, op}, "R1 command pop", {o_pop, o_bus}, {2'd1, op, op});
      if (cnt == 8'hFF) begin
        for (int j = 0; j < 8; j++) begin
          send(8'h10 + 8'(j), 8'h99, 8);
          check(o_pop == 1 && o_bus == {8'h10 + 8'(j), 8'h10 + 8'(j)}, "R3 unknown command unstriped", o_pop, 1);
        end
      end else begin
        for (int j = 0; j < int'(cnt); j++) begin
          send(8'h20 + 8'(j), 8'h99, 8);
          check(o_pop == 1 && o_bus[15:8] == o_bus[7:0], "R2 countdown byte unstriped", o_pop, 1);
        end
        send(8'hA5, 8'h3C, 8);
        check(o_pop == 2 && o_bus == 16'h4EB1, "R2 R5 first striped launch", {o_pop, o_bus}, {2'd2, 16'h4EB1});
      end
      end_frame();
    end

    // R5 R6 R11: striped vectors with loopback
    enter_stripe();
    for (int v = 0; v < 5; v++) begin
      send(SV[v][23:16], SV[v][31:24], 8);
      check(o_pop == 2 && o_bus == SV[v][15:0], "R5 stripe map", o_bus, SV[v][15:0]);
      check(o_pop == 2, "R11 stripe holds", o_pop, 2);
      ret(SV[v][15:0], 0);
      check(o_push == 2 && o_data == SV[v][31:16], "R6 inverse map", o_data, SV[v][31:16]);
    end

    // R7 overflow
    send(8'h01, 8'h02, 8);
    ret(16'h1234, 1);
    check(o_over == 1 && o_push == 0, "R7 overflow drops", {o_over, o_push}, {1'b1, 2'd0});

    // R8 underflow in striping keeps state
    send(8'h11, 8'h22, 1);
    check(o_under == 1 && o_pop == 0 && o_launch == 0, "R8 short level", {o_under, o_pop}, {1'b1, 2'd0});
    send(8'hFF, 8'h00, 2);
    check(o_pop == 2 && o_bus == 16'h5555, "R8 state unchanged", o_bus, 16'h5555);

    // R1 frame end returns to command check
    end_frame();
    send(8'h9F, 8'h00, 8);
    check(o_pop == 1 && o_bus == 16'h9F9F, "R1 after frame end", o_bus, 16'h9F9F);
    send(8'h5A, 8'hC3, 8);
    check(o_pop == 1, "R3 none holds", o_pop, 1);
    // R4 unstriped return
    ret(16'hC35A, 0);
    check(o_push == 1 && o_data[7:0] == 8'h5A, "R4 bus0 only", o_data, 16'h005A);
    end_frame();

    // R8 empty in command state
    send(8'h03, 8'h00, 0);
    check(o_under == 1 && o_pop == 0, "R8 empty queue", o_under, 1);
    end_frame();

    // R10 inactive chip select
    @(negedge clk); cs_active = 0; xfer_req = 1; tx_level = 0; #1;
    check(bus_launch == 0 && underflow_evt == 0, "R10 request ignored", {bus_launch, underflow_evt}, 0);
    @(posedge clk); #1 xfer_req = 0;

    // R9 single bus
    cfg_sep_bus = 0;
    enter_stripe();
    send(8'hA5, 8'h3C, 8);
    check(o_pop == 1 && o_bus == 16'hA5A5, "R9 identity tx", {o_pop, o_bus}, {2'd1, 16'hA5A5});
    ret(16'h3CA5, 0);
    check(o_push == 1 && o_data[7:0] == 8'hA5, "R9 single push", {o_push, o_data}, {2'd1, 16'h00A5});
    end_frame();
    cfg_sep_bus = 1; cfg_two_mem = 0;
    enter_stripe();
    send(8'h0F, 8'hF0, 8);
    check(o_pop == 1 && o_bus == 16'h0F0F, "R9 one config bit", o_bus, 16'h0F0F);
    end_frame();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule